// File: doc/BRIEF.md
# I2C Slave Bus Controller with Host Registers

This block is the target side of a two-wire serial bus. It sits behind a small host register port. It synchronises the incoming clock and data lines and finds START and STOP conditions. It shifts in the first byte of each transfer and compares the upper seven bits with an address that the host has programmed. When the address matches, the block records that it has been addressed, raises an interrupt request and, if the host allows it, pulls the data line low for the acknowledge clock. The direction bit then sets what happens next. With a zero the block stays a receiver and collects data bytes for the host. With a one it becomes a transmitter and shifts out the byte the host has loaded, one bit per master clock period.

The host writes one control word. That word holds the outgoing byte, an acknowledge-suppress bit and two stored start/stop request bits. Before it loads data, the host reads a status word to check the addressed flag. An interrupt control word enables the request line, and any write to that word clears a pending request. The data line is driven open-drain: the block only ever asserts a pull-low enable.

Top module: `i2c_slv_ctl`

## Requirements
- R1: After reset, `sda_pull_low` and `irq` are 0, and the own-address, control, status and interrupt words all read back as 0x0000.
- R2: Register index 0 holds the own address in bits 6:0. Index 1 holds the transmit byte in bits 7:0, acknowledge-suppress in bit 8, start request in bit 9 and stop request in bit 10. Both read back exactly what was written to those bits.
- R3: An address byte whose bits 7:1 equal the own address, received while acknowledge-suppress is 0, makes the block hold SDA low for the following acknowledge clock.
- R4: An address byte whose bits 7:1 differ from the own address produces no acknowledge (SDA stays high), leaves the addressed flag clear and raises no interrupt.
- R5: On an address match, status bit 0 (addressed) becomes 1 and an interrupt becomes pending. This happens even when acknowledge-suppress is 1, in which case no acknowledge is driven.
- R6: Register index 3 holds the interrupt enable in bit 8 and reads the pending flag in bit 0. `irq` is high only when both are 1. Any write to index 3 clears the pending flag.
- R7: With direction bit 1, status bit 1 (transmitter) becomes 1 and the loaded byte is driven MSB first, one bit per SCL period, with SDA pulled low for each 0 bit.
- R8: In transmitter mode, a master acknowledge (SDA low on the ninth clock) raises a new interrupt, and the next byte is taken from the control word. A master not-acknowledge releases SDA, clears the transmitter flag and sets status bit 2.
- R9: With direction bit 0, each received data byte appears in status bits 15:8. It is acknowledged unless acknowledge-suppress is 1.
- R10: A STOP, or a START (including a repeated START in the middle of a byte), clears the addressed flag and restarts bit counting at the next address byte.
- R11: `sda_pull_low` only ever asserts while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write strobe |
| reg_wr_addr | input | 2 | Host write register index |
| reg_wr_data | input | 16 | Host write data |
| reg_rd_addr | input | 2 | Host read register index |
| reg_rd_data | output | 16 | Registered read data for the index selected on the previous cycle |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
A bus edge takes three clocks to act on `sda_pull_low`: two synchroniser stages, then the engine register. The interrupt line follows two clocks after that. A register read returns one clock after the index is applied. The bench master holds each SCL phase for six clocks and changes SDA only in the low phase. It samples the line three clocks into the high phase, when any slave drive is long settled. Status and interrupt checks are made only after the whole bit sequence has finished, and reads wait one full clock before sampling.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int IDX_W  = 2;

  localparam logic [IDX_W-1:0] IDX_OWN  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_TXC  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_STAT = 2'd2;
  localparam logic [IDX_W-1:0] IDX_IRQ  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_t;

  typedef struct packed {
    logic              stop_req;
    logic              start_req;
    logic              ack_off;
    logic [BYTE_W-1:0] data;
  } txc_t;
endpackage

// File: rtl/i2c_slv_line_sync.sv
module i2c_slv_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sda_s,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic [DW-2:0]             own_addr,
  input  logic [DW-1:0]             tx_byte,
  input  logic                      ack_off,
  output logic                      sda_oe,
  output logic                      addressed,
  output logic                      tx_mode,
  output logic                      nack_seen,
  output logic [DW-1:0]             rx_byte,
  output logic                      irq_evt,
  output logic [$clog2(DW+1)-1:0]   bit_cnt
);
  localparam int CNT_W = $clog2(DW+1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW-1);

  bus_state_t    state;
  logic [DW-1:0] shreg;
  logic          rw_q;

  always_ff @(posedge clk) begin
    irq_evt <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      tx_mode   <= 1'b0;
      nack_seen <= 1'b0;
      rx_byte   <= '0;
      rw_q      <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      tx_mode   <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      tx_mode   <= 1'b0;
      nack_seen <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == CNT_FULL) begin
            bit_cnt <= '0;
            if (shreg[DW-1:1] == own_addr) begin
              addressed <= 1'b1;
              rw_q      <= shreg[0];
              irq_evt   <= 1'b1;
              sda_oe    <= ~ack_off;
              state     <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_mode <= 1'b1;
              shreg   <= tx_byte;
              sda_oe  <= ~tx_byte[DW-1];
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == CNT_LAST) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              state   <= ST_TX_ACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[DW-2:0], 1'b0};
              sda_oe  <= ~shreg[DW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_seen <= sda_s;
            if (!sda_s) irq_evt <= 1'b1;
          end else if (scl_fall) begin
            if (nack_seen) begin
              tx_mode <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[DW-1];
              state  <= ST_TX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            shreg   <= {shreg[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == CNT_FULL) begin
            bit_cnt <= '0;
            rx_byte <= shreg;
            sda_oe  <= ~ack_off;
            state   <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              addressed,
  input  logic              tx_mode,
  input  logic              nack_seen,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              irq_evt,
  output logic [BYTE_W-2:0] own_addr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ack_off,
  output logic              irq_en,
  output logic              irq_pend,
  output logic              irq
);
  txc_t txc;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:BYTE_W+3], wr_data[BYTE_W-1]};
  assign tx_byte = txc.data;
  assign ack_off = txc.ack_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= '0;
      txc      <= '0;
      irq_en   <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        IDX_OWN: own_addr <= wr_data[BYTE_W-2:0];
        IDX_TXC: txc      <= wr_data[BYTE_W+2:0];
        IDX_IRQ: irq_en   <= wr_data[BYTE_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
    end else if (irq_evt) begin
      irq_pend <= 1'b1;
    end else if (wr_en && wr_addr == IDX_IRQ) begin
      irq_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_pend & irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        IDX_OWN:  rd_data <= REG_W'(own_addr);
        IDX_TXC:  rd_data <= REG_W'(txc);
        IDX_STAT: rd_data <= {rx_byte, 5'b0, nack_seen, tx_mode, addressed};
        default:  rd_data <= {7'b0, irq_en, 7'b0, irq_pend};
      endcase
    end
  end
endmodule

// File: rtl/i2c_slv_ctl.sv
module i2c_slv_ctl
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [IDX_W-1:0] reg_wr_addr,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [IDX_W-1:0] reg_rd_addr,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull_low,
  output logic             irq
);
  localparam int CNT_W = $clog2(BYTE_W+1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-2:0] own_addr;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic ack_off, addressed, tx_mode, nack_seen, irq_evt, irq_en, irq_pend;
  logic [CNT_W-1:0] bit_cnt;
  logic unused_scl_level;

  assign unused_scl_level = scl_s ^ (^bit_cnt);

  i2c_slv_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_in), .sda_i(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slv_engine #(.DW(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
    .tx_byte(tx_byte), .ack_off(ack_off), .sda_oe(sda_pull_low),
    .addressed(addressed), .tx_mode(tx_mode), .nack_seen(nack_seen),
    .rx_byte(rx_byte), .irq_evt(irq_evt), .bit_cnt(bit_cnt)
  );

  i2c_slv_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .addressed(addressed), .tx_mode(tx_mode), .nack_seen(nack_seen),
    .rx_byte(rx_byte), .irq_evt(irq_evt), .own_addr(own_addr),
    .tx_byte(tx_byte), .ack_off(ack_off), .irq_en(irq_en),
    .irq_pend(irq_pend), .irq(irq)
  );
endmodule

// File: rtl/i2c_slv_ctl_chk.sv
module i2c_slv_ctl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             sda_pull_low,
  input logic             irq,
  input logic             irq_en,
  input logic             irq_pend,
  input logic             irq_evt,
  input logic             addressed,
  input logic             tx_mode,
  input logic             start_det,
  input logic             stop_det,
  input logic [CNT_W-1:0] bit_cnt
);
  p_pull_low_phase_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !scl_s);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en);

  p_evt_pends_r5: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> irq_pend);

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!addressed && bit_cnt == '0));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!addressed && bit_cnt == '0));

  p_tx_needs_addr_r7: assert property (@(posedge clk) disable iff (rst)
    tx_mode |-> addressed);
endmodule

bind i2c_slv_ctl i2c_slv_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull_low(sda_pull_low),
  .irq(irq), .irq_en(irq_en), .irq_pend(irq_pend), .irq_evt(irq_evt),
  .addressed(addressed), .tx_mode(tx_mode), .start_det(start_det),
  .stop_det(stop_det), .bit_cnt(bit_cnt)
);

// File: tb/i2c_slv_ctl_tb_top.sv
module i2c_slv_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 6;
  localparam int NVEC = 6;
  // fields: own[17:11] addr_byte[10:3] ack_off[2] exp_ack[1] exp_addressed[0]
  localparam logic [17:0] VEC [NVEC] = '{
    {7'h24, 8'h48, 1'b0, 1'b1, 1'b1},
    {7'h24, 8'h4A, 1'b0, 1'b0, 1'b0},
    {7'h7F, 8'hFE, 1'b0, 1'b1, 1'b1},
    {7'h24, 8'h48, 1'b1, 1'b0, 1'b1},
    {7'h00, 8'h00, 1'b0, 1'b1, 1'b1},
    {7'h24, 8'hC8, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_pull_low, irq;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign sda_line = ~(m_low | sda_pull_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slv_ctl dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .scl_in(m_scl), .sda_in(sda_line), .sda_pull_low(sda_pull_low), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic bus_start;
    m_low = 1'b0; wait_n(PH);
    m_scl = 1'b1; wait_n(PH);
    m_low = 1'b1; wait_n(PH);
    m_scl = 1'b0; wait_n(PH);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wait_n(PH);
    m_scl = 1'b1; wait_n(PH);
    m_low = 1'b0; wait_n(PH);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; wait_n(PH);
    m_scl = 1'b1; wait_n(PH);
    m_scl = 1'b0; wait_n(2);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wait_n(PH);
    m_scl = 1'b1; wait_n(PH/2);
    b = sda_line; wait_n(PH/2);
    m_scl = 1'b0; wait_n(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic ack;
    logic [7:0] byte_v;

    wait_n(4);
    rst = 1'b0;
    wait_n(2);

    // R1 reset state
    chk("R1 pull_low", {15'b0, sda_pull_low}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    reg_rd(2'd0, r); chk("R1 own", r, 16'h0);
    reg_rd(2'd1, r); chk("R1 txc", r, 16'h0);
    reg_rd(2'd2, r); chk("R1 status", r, 16'h0);
    reg_rd(2'd3, r); chk("R1 irqctl", r, 16'h0);

    // R2 register readback
    reg_wr(2'd0, 16'h0024); reg_rd(2'd0, r); chk("R2 own", r, 16'h0024);
    reg_wr(2'd1, 16'h0655); reg_rd(2'd1, r); chk("R2 txc", r, 16'h0655);

    // Table walk: R3 R4 R5 R10
    for (int v = 0; v < NVEC; v++) begin
      reg_wr(2'd0, {9'b0, VEC[v][17:11]});
      reg_wr(2'd1, {7'b0, VEC[v][2], 8'h00});
      reg_wr(2'd3, 16'h0100);
      bus_start();
      send_byte(VEC[v][10:3], ack);
      chk($sformatf("R3 R4 ack vec%0d", v), {15'b0, ack}, {15'b0, VEC[v][1]});
      reg_rd(2'd2, r);
      chk($sformatf("R5 addressed vec%0d", v), {15'b0, r[0]}, {15'b0, VEC[v][0]});
      chk($sformatf("R5 irq vec%0d", v), {15'b0, irq}, {15'b0, VEC[v][0]});
      bus_stop();
      reg_rd(2'd2, r);
      chk($sformatf("R10 stop clears vec%0d", v), {15'b0, r[0]}, 16'h0);
    end

    // R6 enable gating and clear on write
    reg_wr(2'd0, 16'h0024);
    reg_wr(2'd1, 16'h0000);
    reg_wr(2'd3, 16'h0000);
    bus_start();
    send_byte(8'h48, ack);
    chk("R6 irq masked", {15'b0, irq}, 16'h0);
    reg_rd(2'd3, r); chk("R6 pending", r, 16'h0001);
    reg_wr(2'd3, 16'h0100);
    reg_rd(2'd3, r); chk("R6 cleared", r, 16'h0100);
    chk("R6 irq after clear", {15'b0, irq}, 16'h0);
    bus_stop();

    // R7 R8 transmitter
    reg_wr(2'd1, 16'h0055);
    reg_wr(2'd3, 16'h0100);
    bus_start();
    send_byte(8'h49, ack);
    chk("R7 addr ack", {15'b0, ack}, 16'h1);
    reg_rd(2'd2, r); chk("R7 tx flag", r[1:0], 2'b11);
    reg_wr(2'd1, 16'h01A3);
    reg_wr(2'd3, 16'h0100);
    recv_byte(byte_v);
    chk("R7 first byte", {8'h0, byte_v}, 16'h0055);
    send_bit(1'b0);
    chk("R8 irq on master ack", {15'b0, irq}, 16'h1);
    reg_wr(2'd3, 16'h0100);
    recv_byte(byte_v);
    chk("R8 next byte", {8'h0, byte_v}, 16'h00A3);
    send_bit(1'b1);
    wait_n(4);
    chk("R8 released", {15'b0, sda_pull_low}, 16'h0);
    chk("R8 no irq on nack", {15'b0, irq}, 16'h0);
    reg_rd(2'd2, r); chk("R8 status after nack", r[2:0], 3'b101);
    bus_stop();

    // R9 receiver
    reg_wr(2'd1, 16'h0000);
    bus_start();
    send_byte(8'h48, ack);
    send_byte(8'h3C, ack);
    chk("R9 data ack", {15'b0, ack}, 16'h1);
    reg_rd(2'd2, r); chk("R9 rx byte", r[15:8], 8'h3C);
    reg_wr(2'd1, 16'h0100);
    send_byte(8'h81, ack);
    chk("R9 suppressed ack", {15'b0, ack}, 16'h0);
    reg_rd(2'd2, r); chk("R9 rx byte2", r[15:8], 8'h81);
    bus_stop();

    // R10 repeated start mid-byte
    reg_wr(2'd1, 16'h0000);
    bus_start();
    send_byte(8'h48, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    reg_rd(2'd2, r); chk("R10 restart clears", {15'b0, r[0]}, 16'h0);
    send_byte(8'h48, ack);
    chk("R10 count restarted", {15'b0, ack}, 16'h1);
    bus_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule